// File: doc/BRIEF.md
# Vectored Interrupt Controller with Latched External Source

The controller gathers ninety-six interrupt sources into three 32-bit banks. For each bank it holds a pending word, an enable word and a mask word, and it drives a single interrupt line to the processor. Software reads a vector register to learn the number of the most urgent source that is both enabled and not masked. The number appears shifted left by two. A vector reading of zero is ambiguous, so software resolves it by checking bit 0 of pending bank 0.

Sources 1 to 95 are level inputs, and their pending bits follow the input lines directly. Source 0 is an external line. It passes through a two-flop synchronizer and a trigger detector whose type software selects. A small state machine captures it and holds it until software writes a one to its pending bit. The state machine has two states. `EXT_IDLE` means nothing is latched, and `EXT_HELD` means source 0 is latched. Transition `T_CAPTURE` (EXT_IDLE to EXT_HELD) fires when the trigger condition is seen. Transition `T_ACK` (EXT_HELD to EXT_IDLE) fires on an acknowledge write when no trigger is present in the same cycle. A stored protection bit and the trigger-type field complete the register set. Register reads return data one clock after the read strobe.

Top module: `vic_top`

## Requirements
- R1: After reset, all enable, mask, protection and trigger-type registers read zero, `irq_o` is low and the vector (offset 0x00) reads zero.
- R2: Enable words at offsets 0x40/0x44/0x48 and mask words at 0x50/0x54/0x58 (bank 0/1/2) read back what was written, with read data valid one cycle after `bus_rd_i`.
- R3: Pending words at 0x10/0x14/0x18 show the current level of sources 1..95 (source n at bank n/32, bit n%32). Writing ones to those bits has no effect.
- R4: A source is active when its pending, enable and not-mask bits are all true. `irq_o` is high in the cycle after any source is active and low in the cycle after none is.
- R5: The vector register returns the lowest active source number in bits [8:2], with all other bits zero. It reads zero when no source is active.
- R6: Source 0, once captured, stays pending until a write to offset 0x10 with data bit 0 set. A write with bit 0 clear leaves it pending.
- R7: Bits [1:0] at offset 0x0C select the source-0 trigger: 0 low level, 1 high level, 2 falling edge, 3 rising edge. The trigger is judged on the input after a two-flop synchronizer whose flops reset to one.
- R8: With source 0 pending and enabled, the vector reads 0 and `irq_o` is high, while bit 0 of pending bank 0 reads 1.
- R9: Bit 0 at offset 0x08 is a read-write protection bit. The other bits of that word read zero.
- R10: Offsets 0x20..0x2C (fast-interrupt pending) and every undecoded offset read zero.
- R11: If a trigger and an acknowledge arrive in the same cycle, source 0 stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Read data, registered on a read strobe |
| ext_irq_i | input | 1 | Asynchronous external source 0 |
| lvl_src_i | input | NUM_BANKS*32-1 | Level sources 1..95 (index = source number) |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench targets the zero-vector ambiguity. It expects a vector of zero together with a set pending bit when source 0 is latched. A controller that encoded source 0 as "nothing" would still raise the line but hide the source.

It mixes enable and mask patterns across bank boundaries, including sources 33, 70 and 95. An off-by-one in the bank or bit split, or a highest-first priority order, shows up as a wrong vector.

Each trigger type is driven with both the matching and the opposite transition, and acknowledges are issued with bit 0 clear and while a level trigger is still asserted. A design that treated edges as levels, let a zero write clear the latch, or let the acknowledge win over a concurrent trigger would show the wrong pending state.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int BANK_W = 32;

    // Register byte offsets; bank words sit at base + 4*bank
    localparam int OFF_VECTOR   = 'h00;
    localparam int OFF_PROT     = 'h08;
    localparam int OFF_TRIG     = 'h0C;
    localparam int OFF_PEND     = 'h10;
    localparam int OFF_FAST     = 'h20;
    localparam int OFF_ENABLE   = 'h40;
    localparam int OFF_MASK     = 'h50;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_RISE = 2'd3
    } trig_mode_e;

    typedef enum logic {
        EXT_IDLE = 1'b0,
        EXT_HELD = 1'b1
    } ext_state_e;
endpackage

// File: rtl/vic_bank_regs.sv
module vic_bank_regs
    import vic_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_we_i,
    input  logic              mask_we_i,
    input  logic [BANK_W-1:0] wdata_i,
    output logic [BANK_W-1:0] en_o,
    output logic [BANK_W-1:0] mask_o
);
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            en_o   <= '0;
            mask_o <= '0;
        end else begin
            if (en_we_i)   en_o   <= wdata_i;
            if (mask_we_i) mask_o <= wdata_i;
        end
    end
endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
    parameter int N     = 96,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     act_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);
    // Lowest index wins: scan downward so the last hit is the smallest
    always_comb begin
        idx_o = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (act_i[k]) idx_o = IDX_W'(k);
        end
        valid_o = |act_i;
    end
endmodule

// File: rtl/vic_ext_latch.sv
module vic_ext_latch
    import vic_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       ext_i,
    input  trig_mode_e mode_i,
    input  logic       ack_i,
    output logic       capture_o,
    output logic       pend_o
);
    logic       sync1_q, sync2_q, prev_q;
    ext_state_e state_q, state_d;

    // Synchronizer and history flop; reset high for an idle-high line
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
            prev_q  <= 1'b1;
        end else begin
            sync1_q <= ext_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    always_comb begin
        unique case (mode_i)
            TRIG_LOW:  capture_o = !sync2_q;
            TRIG_HIGH: capture_o = sync2_q;
            TRIG_FALL: capture_o = prev_q && !sync2_q;
            TRIG_RISE: capture_o = !prev_q && sync2_q;
            default:   capture_o = 1'b0;
        endcase
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= EXT_IDLE;
        else         state_q <= state_d;
    end

    // Transitions: T_CAPTURE and T_ACK (capture wins over ack)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EXT_IDLE: if (capture_o)          state_d = EXT_HELD;
            EXT_HELD: if (ack_i && !capture_o) state_d = EXT_IDLE;
            default:                           state_d = EXT_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        pend_o = (state_q == EXT_HELD);
    end
endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int ADDR_W    = 8
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [ADDR_W-1:0]         bus_addr_i,
    input  logic                      bus_wr_i,
    input  logic [BANK_W-1:0]         bus_wdata_i,
    input  logic                      bus_rd_i,
    output logic [BANK_W-1:0]         bus_rdata_o,
    input  logic                      ext_irq_i,
    input  logic [NUM_BANKS*BANK_W-1:1] lvl_src_i,
    output logic                      irq_o
);
    localparam int NUM_SRC = NUM_BANKS * BANK_W;
    localparam int IDX_W   = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] en_all, mask_all, pend_all, active;
    logic               prot_q;
    trig_mode_e         trig_q;
    logic               src0_ack, src0_cap, src0_pend;
    logic               vec_valid;
    logic [IDX_W-1:0]   vec_idx;
    logic [BANK_W-1:0]  rdata_d;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic en_we, mask_we;
        assign en_we   = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_ENABLE + 4 * b));
        assign mask_we = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_MASK + 4 * b));
        vic_bank_regs u_regs (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .en_we_i   (en_we),
            .mask_we_i (mask_we),
            .wdata_i   (bus_wdata_i),
            .en_o      (en_all[b*BANK_W +: BANK_W]),
            .mask_o    (mask_all[b*BANK_W +: BANK_W])
        );
    end

    assign src0_ack = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_PEND)) && bus_wdata_i[0];

    vic_ext_latch u_ext (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ext_i     (ext_irq_i),
        .mode_i    (trig_q),
        .ack_i     (src0_ack),
        .capture_o (src0_cap),
        .pend_o    (src0_pend)
    );

    assign pend_all = {lvl_src_i, src0_pend};
    assign active   = pend_all & en_all & ~mask_all;

    vic_prio_enc #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
        .act_i   (active),
        .valid_o (vec_valid),
        .idx_o   (vec_idx)
    );

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            prot_q <= 1'b0;
            trig_q <= TRIG_LOW;
            irq_o  <= 1'b0;
        end else begin
            if (bus_wr_i && bus_addr_i == ADDR_W'(OFF_PROT)) prot_q <= bus_wdata_i[0];
            if (bus_wr_i && bus_addr_i == ADDR_W'(OFF_TRIG)) trig_q <= trig_mode_e'(bus_wdata_i[1:0]);
            irq_o <= |active;
        end
    end

    // Read decode; fast-interrupt words and unknown offsets fall through to zero
    always_comb begin
        rdata_d = '0;
        if (bus_addr_i == ADDR_W'(OFF_VECTOR) && vec_valid)
            rdata_d = BANK_W'(vec_idx) << 2;
        if (bus_addr_i == ADDR_W'(OFF_PROT))
            rdata_d = {{(BANK_W-1){1'b0}}, prot_q};
        if (bus_addr_i == ADDR_W'(OFF_TRIG))
            rdata_d = {{(BANK_W-2){1'b0}}, trig_q};
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr_i == ADDR_W'(OFF_PEND + 4 * b))   rdata_d = pend_all[b*BANK_W +: BANK_W];
            if (bus_addr_i == ADDR_W'(OFF_ENABLE + 4 * b)) rdata_d = en_all[b*BANK_W +: BANK_W];
            if (bus_addr_i == ADDR_W'(OFF_MASK + 4 * b))   rdata_d = mask_all[b*BANK_W +: BANK_W];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)       bus_rdata_o <= '0;
        else if (bus_rd_i) bus_rdata_o <= rdata_d;
    end
endmodule

// File: rtl/vic_top_chk.sv
module vic_top_chk #(
    parameter int NUM_SRC = 96,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_SRC-1:0] active_i,
    input logic               irq_i,
    input logic               vec_valid_i,
    input logic [IDX_W-1:0]   vec_idx_i,
    input logic               src0_pend_i,
    input logic               src0_ack_i,
    input logic               src0_cap_i
);
    logic [NUM_SRC-1:0] below;
    assign below = (NUM_SRC'(1) << vec_idx_i) - NUM_SRC'(1);

    p_irq_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|active_i) |=> irq_i);
    p_irq_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(|active_i) |=> !irq_i);
    p_vec_active_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_valid_i |-> active_i[vec_idx_i]);
    p_vec_lowest_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_valid_i |-> ((active_i & below) == '0));
    p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src0_pend_i && !src0_ack_i) |=> src0_pend_i);
    p_ack_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src0_pend_i && src0_ack_i && !src0_cap_i) |=> !src0_pend_i);
    p_capture_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        src0_cap_i |=> src0_pend_i);
endmodule

bind vic_top vic_top_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .irq_i       (irq_o),
    .vec_valid_i (vec_valid),
    .vec_idx_i   (vec_idx),
    .src0_pend_i (src0_pend),
    .src0_ack_i  (src0_ack),
    .src0_cap_i  (src0_cap)
);

// File: tb/vic_top_tb.sv
module vic_top_tb_top;
    localparam logic [95:0] ALL1 = {96{1'b1}};
    localparam int NT = 6;
    localparam logic [95:0] T_SRC [NT] = '{
        96'h1 << 5, (96'h1 << 40) | (96'h1 << 70), (96'h1 << 40) | (96'h1 << 70),
        96'h1 << 95, (96'h1 << 10) | (96'h1 << 33), 96'h1 << 64 };
    localparam logic [95:0] T_EN [NT] = '{ ALL1, ALL1, ALL1, 96'h1 << 95, 96'h1 << 33, ALL1 };
    localparam logic [95:0] T_MSK [NT] = '{ 96'h0, 96'h0, 96'h1 << 40, 96'h0, 96'h0, ALL1 };
    localparam logic [8:0] T_VEC [NT] = '{ 9'h014, 9'h0A0, 9'h118, 9'h17C, 9'h084, 9'h000 };
    localparam logic T_IRQ [NT] = '{ 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0 };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ext = 1'b1;
    logic [95:1] lvl = '0;
    logic        irq;
    int          checks = 0, failures = 0;
    logic [31:0] r;

    always #5 clk = ~clk;

    vic_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
        .bus_wdata_i(wdata), .bus_rd_i(rd), .bus_rdata_o(rdata),
        .ext_irq_i(ext), .lvl_src_i(lvl), .irq_o(irq));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        bus_read(8'h00, r); check("R1 vector", r, 32'h0);
        bus_read(8'h08, r); check("R1 prot", r, 32'h0);
        bus_read(8'h0C, r); check("R1 trig", r, 32'h0);
        bus_read(8'h40, r); check("R1 enable", r, 32'h0);
        bus_read(8'h50, r); check("R1 mask", r, 32'h0);

        // R2: enable and mask readback
        bus_write(8'h48, 32'hA5A5_0F0F);
        bus_write(8'h54, 32'h0000_1234);
        bus_read(8'h48, r); check("R2 enable bank2", r, 32'hA5A5_0F0F);
        bus_read(8'h54, r); check("R2 mask bank1", r, 32'h0000_1234);

        // R3: level pending follows input; W1C has no effect on levels
        lvl[33] = 1'b1;
        idle(1);
        bus_read(8'h14, r); check("R3 pend bank1", r, 32'h2);
        bus_write(8'h14, 32'hFFFF_FFFF);
        bus_read(8'h14, r); check("R3 pend after w1c", r, 32'h2);
        lvl[33] = 1'b0;
        idle(1);
        bus_read(8'h14, r); check("R3 pend dropped", r, 32'h0);

        // R4/R5: table of enable/mask/source patterns
        for (int i = 0; i < NT; i++) begin
            for (int b = 0; b < 3; b++) begin
                bus_write(8'(8'h40 + 4 * b), T_EN[i][b*32 +: 32]);
                bus_write(8'(8'h50 + 4 * b), T_MSK[i][b*32 +: 32]);
            end
            lvl = T_SRC[i][95:1];
            idle(2);
            bus_read(8'h00, r); check("R5 vector", r, {23'b0, T_VEC[i]});
            check("R4 irq", {31'b0, irq}, {31'b0, T_IRQ[i]});
        end
        lvl = '0;
        for (int b = 0; b < 3; b++) begin
            bus_write(8'(8'h40 + 4 * b), 32'h0);
            bus_write(8'(8'h50 + 4 * b), 32'h0);
        end

        // R10: fast-pending and undecoded offsets read zero even with activity
        lvl[1] = 1'b1;
        idle(1);
        bus_read(8'h20, r); check("R10 fast pend", r, 32'h0);
        bus_read(8'h04, r); check("R10 offset 04", r, 32'h0);
        bus_read(8'h30, r); check("R10 offset 30", r, 32'h0);
        lvl[1] = 1'b0;

        // R9: protection bit
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_read(8'h08, r); check("R9 prot set", r, 32'h1);
        bus_write(8'h08, 32'h0);
        bus_read(8'h08, r); check("R9 prot clear", r, 32'h0);

        // R7/R8/R6: low-level trigger (mode 0)
        bus_write(8'h40, 32'h1);
        ext = 1'b0; idle(3); ext = 1'b1; idle(5);
        bus_read(8'h10, r); check("R7 low-level capture", r, 32'h1);
        bus_read(8'h00, r); check("R8 vector zero", r, 32'h0);
        check("R8 irq high", {31'b0, irq}, 32'h1);
        bus_write(8'h10, 32'hFFFF_FFFE); idle(2);
        bus_read(8'h10, r); check("R6 zero write keeps", r, 32'h1);
        bus_write(8'h10, 32'h1); idle(2);
        bus_read(8'h10, r); check("R6 ack clears", r, 32'h0);
        check("R6 irq low after ack", {31'b0, irq}, 32'h0);

        // R7: rising edge (mode 3)
        bus_write(8'h0C, 32'h3);
        ext = 1'b0; idle(5);
        bus_read(8'h10, r); check("R7 rise ignores fall", r, 32'h0);
        ext = 1'b1; idle(5);
        bus_read(8'h10, r); check("R7 rise capture", r, 32'h1);
        bus_write(8'h10, 32'h1); idle(3);
        bus_read(8'h10, r); check("R7 rise no relatch on level", r, 32'h0);

        // R7: falling edge (mode 2)
        bus_write(8'h0C, 32'h2);
        ext = 1'b0; idle(5);
        bus_read(8'h10, r); check("R7 fall capture", r, 32'h1);
        bus_write(8'h10, 32'h1); idle(3);
        bus_read(8'h10, r); check("R7 fall cleared", r, 32'h0);
        ext = 1'b1; idle(5);
        bus_read(8'h10, r); check("R7 fall ignores rise", r, 32'h0);

        // R7/R11: high level (mode 1); ack during active trigger keeps pending
        bus_write(8'h0C, 32'h1);
        idle(3);
        bus_read(8'h10, r); check("R7 high-level capture", r, 32'h1);
        bus_write(8'h10, 32'h1);
        bus_read(8'h10, r); check("R11 capture beats ack", r, 32'h1);
        ext = 1'b0; idle(5);
        bus_write(8'h10, 32'h1); idle(2);
        bus_read(8'h10, r); check("R6 ack after release", r, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule